// File: doc/BRIEF.md
# Dual-Word Channel Transmit Packer

This block sits between a local producer of 32-bit words and a point-to-point transmit channel. The channel carries a 64-bit data bus, split into a low and a high 32-bit half, together with a write strobe and a 2-bit code that says which halves hold data. The block pairs consecutive words from the producer into full 64-bit beats. The first word of a pair goes in the low half and the second in the high half. A flush request pushes a lone pending word out as a half beat, in the low half.

The receiver returns a ready level, and the block raises write only while that level is high. A beat that cannot leave stays in a one-beat output slot. While the slot is blocked the block lowers its upstream ready, so the producer's valid/ready handshake stalls. The whole block runs on one clock and uses a synchronous active-high reset.

Top module: `dword_tx_packer`

## Requirements
- R1: Two accepted words with no flush in between form one beat. The earlier word is in ch_data[31:0], the later word is in ch_data[63:32], and ch_vw is 2'b11.
- R2: A flush while one word is pending and no word is accepted sends that word alone. It appears in ch_data[31:0], ch_data[63:32] is zero and ch_vw is 2'b01.
- R3: A flush while no word is pending and no word is accepted has no effect: no write follows.
- R4: A word accepted together with a flush, with nothing pending, goes out alone as an R2-style half beat. A word accepted together with a flush while a word is pending completes a full R1 beat, and nothing remains pending afterwards.
- R5: ch_write is high only while ch_ready is high. A finished beat waits unchanged until ch_ready is high.
- R6: in_ready is low exactly when a finished beat is waiting and ch_ready is low. While in_ready is low, in_valid and flush are ignored.
- R7: While ch_write is low, ch_data and ch_vw are driven to zero. While ch_write is high, ch_vw is only 2'b01 or 2'b11.
- R8: A beat completed at a clock edge is offered in the very next cycle, and ch_write rises in that cycle if ch_ready is high.
- R9: Reset discards any pending word and deasserts ch_write. in_ready is high right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word valid |
| in_word | input | 32 | Upstream data word |
| in_ready | output | 1 | Block can take a word (and a flush) this cycle |
| flush | input | 1 | Push out a half-filled beat |
| ch_ready | input | 1 | Receiver ready level |
| ch_write | output | 1 | Channel write strobe |
| ch_data | output | 64 | Channel data: low half, high half |
| ch_vw | output | 2 | Valid-words code: 01 low half only, 11 both halves |

## Verification
The main function is swept over every combination of 4-cycle patterns of in_valid, flush and ch_ready. This covers several distinct cases:
- Back-to-back pairs, which check word order in the beat.
- Lone flushed words, which check the half-beat code and the zeroed upper half.
- Flushes that arrive with the word completing a pair, which tell a full beat from a spurious extra half beat.
- Ready gaps, which separate correct stalling from lost or duplicated beats.

Directed sequences isolate the empty-flush case, the case where inputs are ignored while stalled, and reset in the middle of a pair.

// File: rtl/dwpk_pkg.sv
package dwpk_pkg;
    localparam logic [1:0] VW_IDLE = 2'b00;
    localparam logic [1:0] VW_LOW  = 2'b01;
    localparam logic [1:0] VW_BOTH = 2'b11;
endpackage

// File: rtl/dwpk_pair_stage.sv
// Holds the lower word of a pair and proposes a beat when a pair completes
// or a flush pushes out a lone word.
module dwpk_pair_stage #(
    parameter int WORD_W = 32,
    localparam int BEAT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              flush_go,
    input  logic [WORD_W-1:0] word,
    output logic              beat_go,
    output logic [BEAT_W-1:0] beat_data,
    output logic [1:0]        beat_vw
);
    import dwpk_pkg::*;

    typedef struct packed {
        logic              have;
        logic [WORD_W-1:0] low;
    } pair_t;

    pair_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        beat_go   = 1'b0;
        beat_data = '0;
        beat_vw   = VW_IDLE;
        if (take && p_q.have) begin
            beat_go   = 1'b1;
            beat_data = {word, p_q.low};
            beat_vw   = VW_BOTH;
            p_d.have  = 1'b0;
        end else if (take && flush_go) begin
            beat_go   = 1'b1;
            beat_data = {{WORD_W{1'b0}}, word};
            beat_vw   = VW_LOW;
        end else if (take) begin
            p_d.have  = 1'b1;
            p_d.low   = word;
        end else if (p_q.have && flush_go) begin
            beat_go   = 1'b1;
            beat_data = {{WORD_W{1'b0}}, p_q.low};
            beat_vw   = VW_LOW;
            p_d.have  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/dwpk_beat_slot.sv
// One-beat output register; loads only when it is free or draining.
module dwpk_beat_slot #(
    parameter int WORD_W = 32,
    localparam int BEAT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open,
    input  logic              beat_go,
    input  logic [BEAT_W-1:0] beat_data,
    input  logic [1:0]        beat_vw,
    output logic              slot_valid,
    output logic [BEAT_W-1:0] slot_data,
    output logic [1:0]        slot_vw
);
    import dwpk_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [BEAT_W-1:0] data;
        logic [1:0]        vw;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (open) begin
            s_d.valid = beat_go;
            s_d.data  = beat_go ? beat_data : '0;
            s_d.vw    = beat_go ? beat_vw : VW_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_valid = s_q.valid;
    assign slot_data  = s_q.data;
    assign slot_vw    = s_q.vw;
endmodule

// File: rtl/dwpk_chan_drive.sv
// Gates the slot onto the channel against the receiver's ready level.
module dwpk_chan_drive #(
    parameter int WORD_W = 32,
    localparam int BEAT_W = 2 * WORD_W
) (
    input  logic              slot_valid,
    input  logic [BEAT_W-1:0] slot_data,
    input  logic [1:0]        slot_vw,
    input  logic              ch_ready,
    output logic              open,
    output logic              ch_write,
    output logic [BEAT_W-1:0] ch_data,
    output logic [1:0]        ch_vw
);
    import dwpk_pkg::*;

    always_comb begin
        open     = !slot_valid || ch_ready;
        ch_write = slot_valid && ch_ready;
        ch_data  = ch_write ? slot_data : '0;
        ch_vw    = ch_write ? slot_vw : VW_IDLE;
    end
endmodule

// File: rtl/dword_tx_packer.sv
module dword_tx_packer #(
    parameter int WORD_W = 32,
    localparam int BEAT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              flush,
    input  logic              ch_ready,
    output logic              ch_write,
    output logic [BEAT_W-1:0] ch_data,
    output logic [1:0]        ch_vw
);
    logic              open;
    logic              take;
    logic              flush_go;
    logic              beat_go;
    logic [BEAT_W-1:0] beat_data;
    logic [1:0]        beat_vw;
    logic              slot_valid;
    logic [BEAT_W-1:0] slot_data;
    logic [1:0]        slot_vw;

    assign in_ready = open;
    assign take     = in_valid && open;
    assign flush_go = flush && open;

    dwpk_pair_stage #(.WORD_W(WORD_W)) i_pair (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .flush_go  (flush_go),
        .word      (in_word),
        .beat_go   (beat_go),
        .beat_data (beat_data),
        .beat_vw   (beat_vw)
    );

    dwpk_beat_slot #(.WORD_W(WORD_W)) i_slot (
        .clk        (clk),
        .rst        (rst),
        .open       (open),
        .beat_go    (beat_go),
        .beat_data  (beat_data),
        .beat_vw    (beat_vw),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .slot_vw    (slot_vw)
    );

    dwpk_chan_drive #(.WORD_W(WORD_W)) i_drive (
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .slot_vw    (slot_vw),
        .ch_ready   (ch_ready),
        .open       (open),
        .ch_write   (ch_write),
        .ch_data    (ch_data),
        .ch_vw      (ch_vw)
    );
endmodule

// File: rtl/dword_tx_packer_chk.sv
module dword_tx_packer_chk #(
    parameter int WORD_W = 32,
    localparam int BEAT_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              ch_ready,
    input logic              ch_write,
    input logic [BEAT_W-1:0] ch_data,
    input logic [1:0]        ch_vw,
    input logic              slot_valid,
    input logic [BEAT_W-1:0] slot_data,
    input logic [1:0]        slot_vw
);
    p_write_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ch_write |-> ch_ready);

    p_waiting_beat_held_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !ch_ready) |=> (slot_valid && $stable(slot_data) && $stable(slot_vw)));

    p_stall_upstream_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !ch_ready) |-> !in_ready);

    p_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
        ch_write |-> (ch_vw == 2'b01 || ch_vw == 2'b11));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !ch_write |-> (ch_data == '0 && ch_vw == 2'b00));

    p_half_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ch_write && ch_vw == 2'b01) |-> (ch_data[BEAT_W-1:WORD_W] == '0));

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ch_write && in_ready));
endmodule

bind dword_tx_packer dword_tx_packer_chk #(.WORD_W(WORD_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .ch_ready   (ch_ready),
    .ch_write   (ch_write),
    .ch_data    (ch_data),
    .ch_vw      (ch_vw),
    .slot_valid (slot_valid),
    .slot_data  (slot_data),
    .slot_vw    (slot_vw)
);

// File: tb/test_dword_tx_packer.sv
module test_dword_tx_packer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        flush = 1'b0;
    logic        ch_ready = 1'b0;
    logic        ch_write;
    logic [63:0] ch_data;
    logic [1:0]  ch_vw;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_have;
    logic [31:0] m_low;
    bit          m_slot;
    logic [63:0] m_sdata;
    logic [1:0]  m_svw;
    int          seq = 0;

    // observations of the latest cycle
    bit          o_write, o_ir;
    logic [63:0] o_data;
    logic [1:0]  o_vw;
    logic [31:0] o_word;

    always #(CLK_P/2) clk = ~clk;

    dword_tx_packer i_dword_tx_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .flush(flush), .ch_ready(ch_ready),
        .ch_write(ch_write), .ch_data(ch_data), .ch_vw(ch_vw)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_have = 0; m_low = '0; m_slot = 0; m_sdata = '0; m_svw = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; flush = 1'b0; ch_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
        check(ch_write == 1'b0, "R9 write low after reset", 64'(ch_write), 64'd0);
        check(in_ready == 1'b1, "R9 in_ready high after reset", 64'(in_ready), 64'd1);
    endtask

    // one cycle: drive, compare with model, advance model across the edge
    task automatic cycle(input bit v, input bit f, input bit r);
        bit exp_ir, exp_wr;
        @(negedge clk);
        o_word   = 32'hC000_0000 | 32'(seq);
        in_valid = v; flush = f; ch_ready = r; in_word = o_word;
        #1;
        o_write = ch_write; o_ir = in_ready; o_data = ch_data; o_vw = ch_vw;
        exp_ir = !m_slot || r;
        exp_wr = m_slot && r;
        check(o_ir == exp_ir, "R6 in_ready", 64'(o_ir), 64'(exp_ir));
        check(o_write == exp_wr, "R5/R8 write strobe", 64'(o_write), 64'(exp_wr));
        if (exp_wr) begin
            check(o_data == m_sdata, "R1/R2/R4 beat data", o_data, m_sdata);
            check(o_vw == m_svw, "R7 valid-words code", 64'(o_vw), 64'(m_svw));
        end else begin
            check(o_data == '0 && o_vw == 2'b00, "R7 idle zero", {o_data[61:0], o_vw}, 64'd0);
        end
        if (exp_ir) begin
            if (v && m_have) begin
                m_slot = 1; m_sdata = {o_word, m_low}; m_svw = 2'b11; m_have = 0;
            end else if (v && f) begin
                m_slot = 1; m_sdata = {32'd0, o_word}; m_svw = 2'b01;
            end else if (v) begin
                m_slot = 0; m_have = 1; m_low = o_word;
            end else if (m_have && f) begin
                m_slot = 1; m_sdata = {32'd0, m_low}; m_svw = 2'b01; m_have = 0;
            end else begin
                m_slot = 0;
            end
            if (v) seq++;
        end
    endtask

    task automatic drain();
        cycle(0, 1, 1);
        cycle(0, 0, 1);
        cycle(0, 0, 1);
    endtask

    initial begin
        logic [31:0] wa, wb;
        model_clear();
        do_reset();

        // R1 pairing order
        cycle(1, 0, 1); wa = o_word;
        cycle(1, 0, 1); wb = o_word;
        cycle(0, 0, 1);
        check(o_write && o_data == {wb, wa} && o_vw == 2'b11, "R1 pair order", o_data, {wb, wa});

        // R3 empty flush
        cycle(0, 1, 1);
        cycle(0, 0, 1);
        check(!o_write, "R3 empty flush no write", 64'(o_write), 64'd0);

        // R2 flush of lone pending word
        cycle(1, 0, 1); wa = o_word;
        cycle(0, 1, 1);
        cycle(0, 0, 1);
        check(o_write && o_data == {32'd0, wa} && o_vw == 2'b01, "R2 half beat", o_data, {32'd0, wa});

        // R4 word with flush, nothing pending
        cycle(1, 1, 1); wa = o_word;
        cycle(0, 0, 1);
        check(o_write && o_data == {32'd0, wa} && o_vw == 2'b01, "R4 lone word with flush", o_data, {32'd0, wa});

        // R4 word with flush completing a pair
        cycle(1, 0, 1); wa = o_word;
        cycle(1, 1, 1); wb = o_word;
        cycle(0, 1, 1);
        check(o_write && o_data == {wb, wa} && o_vw == 2'b11, "R4 pair with flush", o_data, {wb, wa});
        cycle(0, 0, 1);
        check(!o_write, "R4 nothing left after pair", 64'(o_write), 64'd0);

        // R5/R6 stall: beat waits, inputs ignored
        cycle(1, 0, 1); wa = o_word;
        cycle(1, 0, 1); wb = o_word;
        cycle(0, 0, 0);
        check(!o_write && !o_ir, "R5/R6 waiting beat stalls", {62'd0, o_write, o_ir}, 64'd0);
        cycle(1, 1, 0);
        check(!o_ir, "R6 inputs ignored while stalled", 64'(o_ir), 64'd0);
        cycle(0, 0, 1);
        check(o_write && o_data == {wb, wa}, "R5 beat held until ready", o_data, {wb, wa});
        cycle(0, 0, 1);
        check(!o_write, "R6 ignored flush left no beat", 64'(o_write), 64'd0);

        // R9 reset discards pending word
        cycle(1, 0, 1);
        do_reset();
        cycle(0, 1, 1);
        cycle(0, 0, 1);
        check(!o_write, "R9 pending word discarded", 64'(o_write), 64'd0);

        // sweep of 4-cycle patterns (R1 R2 R4 R5 R6 R7 R8)
        for (int vm = 0; vm < 16; vm++) begin
            for (int fm = 0; fm < 16; fm++) begin
                for (int rm = 0; rm < 16; rm++) begin
                    for (int c = 0; c < 8; c++) begin
                        cycle(vm[c % 4], fm[c % 4], rm[(c + 1) % 4]);
                    end
                    drain();
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule